// File: doc/BRIEF.md
# Serial-Controlled Audio/Video Switch Register Bank

This block is the control front end of an audio/video routing controller. A host writes up to six control bytes over a two-wire I2C bus. The block holds them and presents every field as a parallel output for the switching matrix. The block is a slave only. The host can read back one status byte. That byte holds a power-on flag, a base-3 code for three connector-format inputs and two sync-present flags.

SCL and SDA are sampled on the system clock. The block releases SDA or pulls it low through `sda_oe_o`, and the pad and pull-up sit outside the block. A write goes into a staging copy, and the live control outputs change only when the transfer is closed by STOP. The outputs therefore never show a partly written set of fields. Each connector-format input arrives as an already sliced 2-bit level.

Top module: `avsw_ctrl_regs`

## Requirements
- R1: The slave answers the 7-bit address 0x48 when `addr_sel_i` is 0 and 0x49 when it is 1. On the wire this is 0x90/0x92 for a write and 0x91/0x93 for a read. Any other address is not acknowledged and changes nothing.
- R2: The slave pulls SDA low in the ninth clock of a matching address byte and of every written data byte. It changes its SDA drive only while SCL is low.
- R3: Data bytes fill control bytes 1 to 6 in order. The fields are placed as follows:
  - Byte 1: [7:4] composite select A and [3:0] composite select B.
  - Byte 2: [7] logic output 0, [6] logic output 1, [5:3] Y/C select A and [2:0] Y/C select B.
  - Byte 3: [7] zero-cross enable, [6] channel-3 mute, [5:3] audio select A and [2:0] audio select B.
  - Byte 4: [7:3] group-delay trim and [2:0] audio select C.
  - Byte 5: [7:5] coarse volume, [4:2] fine volume and [1:0] left/right routing.
  - Byte 6: [7] group-delay switch A, [6] group-delay switch B, [5] sync-source switch A and [4] sync-source switch B.
- R4: The control outputs change only when STOP ends an addressed write. Bytes that the write did not carry keep their previous values.
- R5: Data bytes after the sixth are acknowledged and discarded.
- R6: Reset loads the following control bytes, byte 1 to byte 6: 0x99, 0xFF, 0xFF, 0x87, 0xFC, 0xF0.
- R7: The status byte is {sync B, sync A, format code[4:0], power-on flag}, with bit 7 first. A read sends it MSB first.
- R8: The format code is A + 3·B + 9·C. Each input is 0 (internal), 1 (wide external) or 2 (narrow external). An input value of 3 counts as 2, so the code never exceeds 26.
- R9: The power-on flag is 1 after reset. It goes to 0 when the first write commits at STOP, and reads and unmatched addresses leave it unchanged.
- R10: The status byte is sampled when its first bit is driven. After a master ACK another status byte follows, and after a NACK the slave releases the bus.
- R11: START and STOP are SDA edges while SCL is high. A repeated START during a write discards that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| addr_sel_i | input | 1 | Selects the alternate slave address |
| fmt_a_i | input | 2 | Connector A format level |
| fmt_b_i | input | 2 | Connector B format level |
| fmt_c_i | input | 2 | Connector C format level |
| sync_a_i | input | 1 | Sync present, path A |
| sync_b_i | input | 1 | Sync present, path B |
| cv_sel_a_o | output | 4 | Composite select A |
| cv_sel_b_o | output | 4 | Composite select B |
| lout_a_o | output | 1 | Logic output 0 |
| lout_b_o | output | 1 | Logic output 1 |
| yc_sel_a_o | output | 3 | Y/C select A |
| yc_sel_b_o | output | 3 | Y/C select B |
| zc_en_o | output | 1 | Zero-cross gating enable |
| ch3_mute_o | output | 1 | Channel-3 mute |
| aud_sel_a_o | output | 3 | Audio select A |
| aud_sel_b_o | output | 3 | Audio select B |
| aud_sel_c_o | output | 3 | Audio select C |
| gd_trim_o | output | 5 | Group-delay trim |
| vol_coarse_o | output | 3 | Coarse volume step |
| vol_fine_o | output | 3 | Fine volume step |
| lr_route_o | output | 2 | Channel-3 left/right routing |
| gd_sw_a_o | output | 1 | Group-delay switch A |
| gd_sw_b_o | output | 1 | Group-delay switch B |
| sync_sw_a_o | output | 1 | Sync-source switch A |
| sync_sw_b_o | output | 1 | Sync-source switch B |

## Verification
Some properties are checked on every cycle:
- the live control image holds still except in the cycle after a commit pulse;
- the power-on flag only falls, and only right after a commit;
- the format code stays at or below 26;
- the slave's SDA drive changes only while the synchronised SCL is low;
- no staging write targets an index beyond the sixth byte.

The bench scenarios show what a cycle property cannot: the exact field positions, the address filter on both select settings, partial writes keeping the bytes they did not carry, discard on repeated START, and the bit order of the status byte.

// File: rtl/avsw_pkg.sv
package avsw_pkg;
  localparam int NUM_CTRL = 6;
  localparam int NUM_FMT  = 3;
  localparam int IDX_W    = $clog2(NUM_CTRL + 1);
  localparam int CODE_W   = 5;
  localparam logic [6:0] DEV_ADDR = 7'h48;

  typedef logic [NUM_CTRL-1:0][7:0] ctrl_img_t;

  // element [0] is control byte 1
  localparam ctrl_img_t CTRL_DEFAULT = {8'hF0, 8'hFC, 8'h87, 8'hFF, 8'hFF, 8'h99};

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WR,
    ST_WACK,
    ST_RD,
    ST_RACK
  } bus_st_t;
endpackage

// File: rtl/avsw_line_sync.sv
module avsw_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES:0] scl_p, sda_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[STAGES-1:0], scl_i};
      sda_p <= {sda_p[STAGES-1:0], sda_i};
    end
  end

  logic scl_prev, sda_prev;
  assign scl_o    = scl_p[STAGES-1];
  assign sda_o    = sda_p[STAGES-1];
  assign scl_prev = scl_p[STAGES];
  assign sda_prev = sda_p[STAGES];

  assign scl_rise_o = scl_o & ~scl_prev;
  assign scl_fall_o = ~scl_o & scl_prev;
  assign start_o    = scl_o & scl_prev & sda_prev & ~sda_o;
  assign stop_o     = scl_o & scl_prev & ~sda_prev & sda_o;
endmodule

// File: rtl/avsw_bus_fsm.sv
module avsw_bus_fsm
  import avsw_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sda_s_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             addr_sel_i,
  input  logic [7:0]       status_i,
  output logic             sda_oe_o,
  output logic             load_o,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [7:0]       wr_data_o,
  output logic             commit_o
);
  bus_st_t          st_q;
  logic [3:0]       cnt_q;
  logic [7:0]       sh_q, tx_q;
  logic             rw_q, mack_q;
  logic [IDX_W-1:0] idx_q;
  logic [6:0]       my_addr;

  assign my_addr = DEV_ADDR | {6'd0, addr_sel_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      sh_q      <= '0;
      tx_q      <= '0;
      rw_q      <= 1'b0;
      mack_q    <= 1'b0;
      idx_q     <= '0;
      sda_oe_o  <= 1'b0;
      load_o    <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_idx_o  <= '0;
      wr_data_o <= '0;
      commit_o  <= 1'b0;
    end else begin
      load_o   <= 1'b0;
      wr_en_o  <= 1'b0;
      commit_o <= 1'b0;
      if (start_i) begin
        st_q     <= ST_ADDR;
        cnt_q    <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop_i) begin
        commit_o <= (st_q == ST_WR) || (st_q == ST_WACK);
        st_q     <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (st_q)
          ST_ADDR: begin
            if (scl_rise_i) begin
              sh_q  <= {sh_q[6:0], sda_s_i};
              cnt_q <= cnt_q + 4'd1;
            end else if (scl_fall_i && cnt_q == 4'd8) begin
              if (sh_q[7:1] == my_addr) begin
                sda_oe_o <= 1'b1;
                rw_q     <= sh_q[0];
                st_q     <= ST_AACK;
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall_i) begin
              cnt_q <= '0;
              if (rw_q) begin
                tx_q     <= status_i;
                sda_oe_o <= ~status_i[7];
                st_q     <= ST_RD;
              end else begin
                sda_oe_o <= 1'b0;
                load_o   <= 1'b1;
                idx_q    <= '0;
                st_q     <= ST_WR;
              end
            end
          end
          ST_WR: begin
            if (scl_rise_i) begin
              sh_q  <= {sh_q[6:0], sda_s_i};
              cnt_q <= cnt_q + 4'd1;
            end else if (scl_fall_i && cnt_q == 4'd8) begin
              // bytes past the last register are acknowledged only
              wr_en_o   <= (idx_q < IDX_W'(NUM_CTRL));
              wr_idx_o  <= idx_q;
              wr_data_o <= sh_q;
              if (idx_q < IDX_W'(NUM_CTRL)) idx_q <= idx_q + 1'b1;
              sda_oe_o  <= 1'b1;
              st_q      <= ST_WACK;
            end
          end
          ST_WACK: begin
            if (scl_fall_i) begin
              sda_oe_o <= 1'b0;
              cnt_q    <= '0;
              st_q     <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_rise_i) begin
              cnt_q <= cnt_q + 4'd1;
            end else if (scl_fall_i) begin
              if (cnt_q == 4'd8) begin
                sda_oe_o <= 1'b0;
                st_q     <= ST_RACK;
              end else begin
                sda_oe_o <= ~tx_q[6];
                tx_q     <= {tx_q[6:0], 1'b0};
              end
            end
          end
          ST_RACK: begin
            if (scl_rise_i) begin
              mack_q <= ~sda_s_i;
            end else if (scl_fall_i) begin
              if (mack_q) begin
                tx_q     <= status_i;
                sda_oe_o <= ~status_i[7];
                cnt_q    <= '0;
                st_q     <= ST_RD;
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/avsw_ctrl_bank.sv
module avsw_ctrl_bank
  import avsw_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [7:0]       wr_data_i,
  input  logic             commit_i,
  output ctrl_img_t        ctrl_o,
  output logic             por_o
);
  ctrl_img_t stg_q;

  for (genvar g = 0; g < NUM_CTRL; g++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stg_q[g]  <= CTRL_DEFAULT[g];
        ctrl_o[g] <= CTRL_DEFAULT[g];
      end else begin
        if (load_i)                                      stg_q[g] <= ctrl_o[g];
        else if (wr_en_i && wr_idx_i == IDX_W'(g))       stg_q[g] <= wr_data_i;
        if (commit_i)                                    ctrl_o[g] <= stg_q[g];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       por_o <= 1'b1;
    else if (commit_i) por_o <= 1'b0;
  end
endmodule

// File: rtl/avsw_status_pack.sv
module avsw_status_pack
  import avsw_pkg::*;
(
  input  logic [NUM_FMT-1:0][1:0] fmt_i,
  input  logic                    sync_a_i,
  input  logic                    sync_b_i,
  input  logic                    por_i,
  output logic [7:0]              status_o
);
  logic [NUM_FMT-1:0][CODE_W-1:0] term;

  for (genvar g = 0; g < NUM_FMT; g++) begin : g_term
    localparam logic [CODE_W-1:0] WEIGHT = CODE_W'(3 ** g);
    logic [1:0] lvl;
    assign lvl     = (fmt_i[g] == 2'd3) ? 2'd2 : fmt_i[g];
    assign term[g] = CODE_W'(lvl) * WEIGHT;
  end

  always_comb begin
    logic [CODE_W-1:0] code;
    code = '0;
    for (int i = 0; i < NUM_FMT; i++) code = code + term[i];
    status_o = {sync_b_i, sync_a_i, code, por_i};
  end
endmodule

// File: rtl/avsw_ctrl_regs.sv
module avsw_ctrl_regs
  import avsw_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic       addr_sel_i,
  input  logic [1:0] fmt_a_i,
  input  logic [1:0] fmt_b_i,
  input  logic [1:0] fmt_c_i,
  input  logic       sync_a_i,
  input  logic       sync_b_i,
  output logic [3:0] cv_sel_a_o,
  output logic [3:0] cv_sel_b_o,
  output logic       lout_a_o,
  output logic       lout_b_o,
  output logic [2:0] yc_sel_a_o,
  output logic [2:0] yc_sel_b_o,
  output logic       zc_en_o,
  output logic       ch3_mute_o,
  output logic [2:0] aud_sel_a_o,
  output logic [2:0] aud_sel_b_o,
  output logic [2:0] aud_sel_c_o,
  output logic [4:0] gd_trim_o,
  output logic [2:0] vol_coarse_o,
  output logic [2:0] vol_fine_o,
  output logic [1:0] lr_route_o,
  output logic       gd_sw_a_o,
  output logic       gd_sw_b_o,
  output logic       sync_sw_a_o,
  output logic       sync_sw_b_o
);
  logic             scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic             load, wr_en, commit, por;
  logic [IDX_W-1:0] wr_idx;
  logic [7:0]       wr_data, status;
  ctrl_img_t        ctrl;

  avsw_line_sync #(.STAGES(2)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  avsw_bus_fsm u_fsm (
    .clk_i, .rst_ni,
    .sda_s_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det),
    .addr_sel_i, .status_i(status),
    .sda_oe_o, .load_o(load), .wr_en_o(wr_en), .wr_idx_o(wr_idx),
    .wr_data_o(wr_data), .commit_o(commit)
  );

  avsw_ctrl_bank u_bank (
    .clk_i, .rst_ni, .load_i(load), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_data_i(wr_data), .commit_i(commit), .ctrl_o(ctrl), .por_o(por)
  );

  avsw_status_pack u_stat (
    .fmt_i({fmt_c_i, fmt_b_i, fmt_a_i}), .sync_a_i, .sync_b_i,
    .por_i(por), .status_o(status)
  );

  assign {cv_sel_a_o, cv_sel_b_o}                        = ctrl[0];
  assign {lout_a_o, lout_b_o, yc_sel_a_o, yc_sel_b_o}    = ctrl[1];
  assign {zc_en_o, ch3_mute_o, aud_sel_a_o, aud_sel_b_o} = ctrl[2];
  assign {gd_trim_o, aud_sel_c_o}                        = ctrl[3];
  assign {vol_coarse_o, vol_fine_o, lr_route_o}          = ctrl[4];
  assign {gd_sw_a_o, gd_sw_b_o, sync_sw_a_o, sync_sw_b_o} = ctrl[5][7:4];
endmodule

// File: rtl/avsw_ctrl_regs_chk.sv
module avsw_ctrl_regs_chk
  import avsw_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             scl_s_i,
  input logic             sda_oe_i,
  input logic             commit_i,
  input logic             por_i,
  input logic             wr_en_i,
  input logic [IDX_W-1:0] wr_idx_i,
  input logic [7:0]       status_i,
  input ctrl_img_t        ctrl_i
);
  assert_hold_until_stop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(ctrl_i));

  assert_por_clears_on_commit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(por_i) |-> $past(commit_i));

  assert_por_never_sets_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(por_i));

  assert_code_in_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_i[5:1] <= 5'd26);

  assert_sda_moves_scl_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_i) |-> !scl_s_i);

  assert_no_write_past_last_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> (wr_idx_i < IDX_W'(NUM_CTRL)));
endmodule

bind avsw_ctrl_regs avsw_ctrl_regs_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s_i(scl_s), .sda_oe_i(sda_oe_o),
  .commit_i(commit), .por_i(por), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
  .status_i(status), .ctrl_i(ctrl)
);

// File: tb/avsw_ctrl_regs_test.sv
module avsw_ctrl_regs_test;
  localparam int Q = 10;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic addr_sel = 1'b0, sync_a = 1'b0, sync_b = 1'b0;
  logic [1:0] fmt_a = 2'd0, fmt_b = 2'd0, fmt_c = 2'd0;
  logic sda_oe, sda_bus;
  logic [3:0] cv_a, cv_b;
  logic lo_a, lo_b, zc, mute, gsa, gsb, ssa, ssb;
  logic [2:0] yc_a, yc_b, au_a, au_b, au_c, vc, vf;
  logic [4:0] gdt;
  logic [1:0] lr;
  int n_chk = 0, n_err = 0;
  logic [5:0][7:0] model;

  always #4 clk = ~clk;
  assign sda_bus = m_sda & ~sda_oe;

  avsw_ctrl_regs uut (
    .clk_i(clk), .rst_ni, .scl_i(m_scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .addr_sel_i(addr_sel), .fmt_a_i(fmt_a), .fmt_b_i(fmt_b), .fmt_c_i(fmt_c),
    .sync_a_i(sync_a), .sync_b_i(sync_b),
    .cv_sel_a_o(cv_a), .cv_sel_b_o(cv_b), .lout_a_o(lo_a), .lout_b_o(lo_b),
    .yc_sel_a_o(yc_a), .yc_sel_b_o(yc_b), .zc_en_o(zc), .ch3_mute_o(mute),
    .aud_sel_a_o(au_a), .aud_sel_b_o(au_b), .aud_sel_c_o(au_c), .gd_trim_o(gdt),
    .vol_coarse_o(vc), .vol_fine_o(vf), .lr_route_o(lr),
    .gd_sw_a_o(gsa), .gd_sw_b_o(gsb), .sync_sw_a_o(ssa), .sync_sw_b_o(ssb)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wq;
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start;
    m_sda = 1'b1; wq; m_scl = 1'b1; wq; m_sda = 1'b0; wq; m_scl = 1'b0; wq;
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; wq; m_scl = 1'b1; wq; m_sda = 1'b1; wq;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wq; m_scl = 1'b1; wq; m_scl = 1'b0;
    end
    m_sda = 1'b1; wq; m_scl = 1'b1; wq; ack = ~sda_bus; m_scl = 1'b0; wq;
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic give_ack);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq; m_scl = 1'b1; wq; b[i] = sda_bus; m_scl = 1'b0;
    end
    m_sda = ~give_ack; wq; m_scl = 1'b1; wq; m_scl = 1'b0; wq; m_sda = 1'b1;
  endtask

  task automatic check_image(input string req);
    chk(req, "cv_sel_a", 32'(cv_a), 32'(model[0][7:4]));
    chk(req, "cv_sel_b", 32'(cv_b), 32'(model[0][3:0]));
    chk(req, "lout_a", 32'(lo_a), 32'(model[1][7]));
    chk(req, "lout_b", 32'(lo_b), 32'(model[1][6]));
    chk(req, "yc_sel_a", 32'(yc_a), 32'(model[1][5:3]));
    chk(req, "yc_sel_b", 32'(yc_b), 32'(model[1][2:0]));
    chk(req, "zc_en", 32'(zc), 32'(model[2][7]));
    chk(req, "ch3_mute", 32'(mute), 32'(model[2][6]));
    chk(req, "aud_sel_a", 32'(au_a), 32'(model[2][5:3]));
    chk(req, "aud_sel_b", 32'(au_b), 32'(model[2][2:0]));
    chk(req, "gd_trim", 32'(gdt), 32'(model[3][7:3]));
    chk(req, "aud_sel_c", 32'(au_c), 32'(model[3][2:0]));
    chk(req, "vol_coarse", 32'(vc), 32'(model[4][7:5]));
    chk(req, "vol_fine", 32'(vf), 32'(model[4][4:2]));
    chk(req, "lr_route", 32'(lr), 32'(model[4][1:0]));
    chk(req, "gd_sw_a", 32'(gsa), 32'(model[5][7]));
    chk(req, "gd_sw_b", 32'(gsb), 32'(model[5][6]));
    chk(req, "sync_sw_a", 32'(ssa), 32'(model[5][5]));
    chk(req, "sync_sw_b", 32'(ssb), 32'(model[5][4]));
  endtask

  function automatic logic [7:0] exp_status(input logic por);
    int c;
    logic [1:0] l [3];
    l[0] = fmt_a; l[1] = fmt_b; l[2] = fmt_c;
    c = 0;
    for (int i = 0; i < 3; i++) c += ((l[i] == 2'd3) ? 2 : int'(l[i])) * (3 ** i);
    return {sync_b, sync_a, 5'(c), por};
  endfunction

  task automatic read_status(input string req, input logic por);
    logic ack;
    logic [7:0] b;
    bus_start;
    send_byte({6'b100100, addr_sel, 1'b1}, ack);
    chk(req, "read address ack", 32'(ack), 32'd1);
    recv_byte(b, 1'b0);
    bus_stop;
    chk(req, "status byte", 32'(b), 32'(exp_status(por)));
  endtask

  task automatic t_reset;
    model = {8'hF0, 8'hFC, 8'h87, 8'hFF, 8'hFF, 8'h99};
    check_image("R6");
    read_status("R9", 1'b1);
  endtask

  task automatic t_status;
    logic ack;
    logic [7:0] b0, b1;
    fmt_a = 2'd1; fmt_b = 2'd0; fmt_c = 2'd0; sync_a = 1'b1; sync_b = 1'b0;
    read_status("R7", 1'b1);
    fmt_a = 2'd2; fmt_b = 2'd1; fmt_c = 2'd1; sync_a = 1'b0; sync_b = 1'b1;
    read_status("R8", 1'b1);
    fmt_a = 2'd2; fmt_b = 2'd2; fmt_c = 2'd2; sync_a = 1'b1; sync_b = 1'b1;
    read_status("R8", 1'b1);
    fmt_a = 2'd3; fmt_b = 2'd0; fmt_c = 2'd3; sync_a = 1'b0; sync_b = 1'b0;
    read_status("R8", 1'b1);
    fmt_a = 2'd0; fmt_b = 2'd2; fmt_c = 2'd1; sync_a = 1'b1; sync_b = 1'b1;
    bus_start;
    send_byte(8'h91, ack);
    recv_byte(b0, 1'b1);
    recv_byte(b1, 1'b0);
    bus_stop;
    chk("R10", "first of two bytes", 32'(b0), 32'(exp_status(1'b1)));
    chk("R10", "second of two bytes", 32'(b1), 32'(exp_status(1'b1)));
    chk("R10", "bus released after nack", 32'(sda_bus), 32'd1);
  endtask

  task automatic t_wrong_addr;
    logic ack;
    addr_sel = 1'b0;
    bus_start;
    send_byte(8'h92, ack);
    chk("R1", "foreign address not acked", 32'(ack), 32'd0);
    send_byte(8'h11, ack);
    bus_stop;
    check_image("R1");
    read_status("R9", 1'b1);
  endtask

  task automatic t_full_write;
    logic ack;
    logic [5:0][7:0] d;
    d = {8'hA5, 8'h4E, 8'h6B, 8'h29, 8'h5C, 8'h3A};
    bus_start;
    send_byte(8'h90, ack);
    chk("R2", "write address ack", 32'(ack), 32'd1);
    for (int i = 0; i < 6; i++) begin
      send_byte(d[i], ack);
      chk("R2", "data byte ack", 32'(ack), 32'd1);
    end
    bus_stop;
    model = d;
    check_image("R3");
    read_status("R9", 1'b0);
  endtask

  task automatic t_commit_on_stop;
    logic ack;
    bus_start;
    send_byte(8'h90, ack);
    send_byte(8'h12, ack);
    send_byte(8'h34, ack);
    check_image("R4");
    bus_stop;
    model[0] = 8'h12; model[1] = 8'h34;
    check_image("R4");
  endtask

  task automatic t_extra_bytes;
    logic ack;
    logic [7:0] d [8];
    d = '{8'hC3, 8'h96, 8'h1E, 8'hE1, 8'h5A, 8'h70, 8'h00, 8'h0F};
    bus_start;
    send_byte(8'h90, ack);
    for (int i = 0; i < 8; i++) begin
      send_byte(d[i], ack);
      if (i >= 6) chk("R5", "surplus byte acked", 32'(ack), 32'd1);
    end
    bus_stop;
    for (int i = 0; i < 6; i++) model[i] = d[i];
    check_image("R5");
  endtask

  task automatic t_restart;
    logic ack;
    logic [7:0] b;
    bus_start;
    send_byte(8'h90, ack);
    send_byte(8'h77, ack);
    send_byte(8'h66, ack);
    bus_start;
    send_byte(8'h91, ack);
    recv_byte(b, 1'b0);
    bus_stop;
    chk("R11", "status after repeated start", 32'(b), 32'(exp_status(1'b0)));
    check_image("R11");
  endtask

  task automatic t_alt_addr;
    logic ack;
    addr_sel = 1'b1;
    bus_start;
    send_byte(8'h90, ack);
    chk("R1", "base address ignored when select high", 32'(ack), 32'd0);
    bus_stop;
    check_image("R1");
    bus_start;
    send_byte(8'h92, ack);
    chk("R1", "alternate address acked", 32'(ack), 32'd1);
    send_byte(8'h55, ack);
    bus_stop;
    model[0] = 8'h55;
    check_image("R1");
    read_status("R1", 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);
    t_reset;
    t_status;
    t_wrong_addr;
    t_full_write;
    t_commit_on_stop;
    t_extra_bytes;
    t_restart;
    t_alt_addr;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule